// File: doc/BRIEF.md
# Memory activity monitor with watermark interrupts

This block watches traffic-event strobes on several independent channels and turns them into per-period activity figures. A shared timer divides the clock into 1 ms ticks and groups those ticks into a programmable sampling period. During each period a channel adds a programmable weight to its accumulator for every cycle in which its event strobe is high. At the end of the period that total becomes the sample. The sample then drives two mechanisms. One is a run-length detector against a raw upper and lower watermark. The other is an exponential moving average, which is compared against its own pair of watermarks.

Software sets up a channel through a small word-addressed register port. It writes the watermarks, the weight, an initial average and a control word, and then writes the global period register. That write starts sampling from a clean state. Interrupt causes collect in a per-channel status word that is cleared by writing ones. Each channel's pending state appears as one bit of a global status word and on a dedicated interrupt output.

Top module: `mem_activity_mon`

## Requirements
- R1: After reset every register reads zero, and `irq` is all zeros.
- R2: The period register (region 0, word 1, bits 7:0) holds the period in ms minus one and reads back as written. A write to it restarts the period timer and clears every channel's accumulator and run counters. A period then lasts (value+1)*CYC_PER_MS cycles, counted from the write edge.
- R3: While a channel runs, each cycle with its event strobe high adds the weight register (word 6) to the accumulator. At period end the average updates as avg += floor((sample - avg) / 2^(K+1)), where K is control bits 13:10. Writing word 3 loads the average, and word 7 reads it back.
- R4: A period whose sample exceeds the upper watermark (word 1) counts toward a run when control bit 30 is set. The run length is control bits 28:26 plus one, and when it completes the period sets status bit 31. Likewise, a sample below the lower watermark (word 2) counts when bit 29 is set, the run length is bits 25:23 plus one, and completion sets status bit 30.
- R5: A period that does not breach a watermark zeroes that watermark's run counter.
- R6: A run counter restarts from zero once its status bit has been set, so the next set needs another full run.
- R7: Writing the status word (word 8) clears exactly the bits written as one. Bits written as zero are kept.
- R8: After an update, an average above the average-upper watermark (word 4) sets status bit 29 if control bit 21 is set. An average below the average-lower watermark (word 5) sets bit 28 if control bit 20 is set. A source whose enable is clear never sets its bit.
- R9: Global status (region 0, word 0) bit 26-c and `irq[c]` are high exactly while channel c has any status bit set.
- R10: With control bit 31 clear, a channel neither accumulates nor updates its average or status. Its initial-average register can still be written. Sampling also requires control bit 18.
- R11: Address bits 7:6 select the region (0 global, c+1 for channel c), bits 5:2 select the word, and bits 1:0 must be zero. `reg_rdata` is valid with `reg_rvalid` on the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NCH | Per-channel traffic-event strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | NCH | Per-channel interrupt pending |

## Verification
The internal state that matters most is the accumulator, the average and the two run counters. All of it becomes visible within a period or two. A wrong accumulator or average shows up in the average readback at the very next period boundary. A run counter that fails to reset, or that counts the wrong way, moves the status bit and `irq` by one or more periods. The bench therefore reads status in the middle of the periods just before and just after the expected set. Gating faults show up as an unexpected bit in the exact status word read one period after the triggering condition.

// File: rtl/mam_pkg.sv
package mam_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  // word offsets inside a channel region
  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_UPWM = 4'd1;
  localparam logic [3:0] OFF_LOWM = 4'd2;
  localparam logic [3:0] OFF_INIT = 4'd3;
  localparam logic [3:0] OFF_AVUP = 4'd4;
  localparam logic [3:0] OFF_AVLO = 4'd5;
  localparam logic [3:0] OFF_WGT  = 4'd6;
  localparam logic [3:0] OFF_AVG  = 4'd7;
  localparam logic [3:0] OFF_STAT = 4'd8;

  // word offsets in the global region
  localparam logic [3:0] OFF_GSTAT = 4'd0;
  localparam logic [3:0] OFF_GPER  = 4'd1;

  // control word fields
  localparam int B_RUN   = 31;
  localparam int B_UPEN  = 30;
  localparam int B_LOEN  = 29;
  localparam int UPN_LSB = 26;
  localparam int LON_LSB = 23;
  localparam int N_W     = 3;
  localparam int B_AUEN  = 21;
  localparam int B_ALEN  = 20;
  localparam int B_PER   = 18;
  localparam int K_LSB   = 10;
  localparam int K_W     = 4;

  // status word fields
  localparam int S_UP = 31;
  localparam int S_LO = 30;
  localparam int S_AU = 29;
  localparam int S_AL = 28;

  // global status: channel c drives bit GSTAT_TOP - c
  localparam int GSTAT_TOP = 26;

  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/mam_timer.sv
module mam_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int PER_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] period_m1,
  output logic             period_end
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0]    cyc_cnt;
  logic [PER_W-1:0] ms_cnt;
  logic             ms_tick;

  assign ms_tick    = (cyc_cnt == CYC_LAST);
  assign period_end = ms_tick && (ms_cnt == period_m1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cyc_cnt <= '0;
      ms_cnt  <= '0;
    end else if (ms_tick) begin
      cyc_cnt <= '0;
      ms_cnt  <= (ms_cnt == period_m1) ? '0 : ms_cnt + 1'b1;
    end else begin
      cyc_cnt <= cyc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mam_channel.sv
module mam_channel
  import mam_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       period_end,
  input  logic       ev,
  input  logic       wr,
  input  logic [3:0] off,
  input  word_t      wdata,
  input  word_t      clr,
  input  logic       init_wr,
  output word_t      rdata,
  output word_t      ctrl_o,
  output word_t      avg_o,
  output word_t      stat_o
);
  word_t ctrl, up_wm, lo_wm, av_up, av_lo, weight, avg, stat, acc;
  logic [N_W-1:0] run_up, run_lo;

  logic           active, sampling;
  logic [DW:0]    acc_sum;
  word_t          sample;
  logic signed [DW+1:0] diff, step;
  logic [4:0]     shamt;
  word_t          avg_new;
  logic           br_up, br_lo, fire_up, fire_lo;
  word_t          set_v;

  assign active   = ctrl[B_RUN];
  assign sampling = period_end && active && ctrl[B_PER];

  // weighted accumulation, saturating at all ones
  assign acc_sum = {1'b0, acc} + ((ev && active) ? {1'b0, weight} : '0);
  assign sample  = acc_sum[DW] ? '1 : acc_sum[DW-1:0];

  // moving average step, floor division by a power of two
  assign shamt   = {1'b0, ctrl[K_LSB +: K_W]} + 5'd1;
  assign diff    = $signed({2'b00, sample}) - $signed({2'b00, avg});
  assign step    = diff >>> shamt;
  assign avg_new = avg + step[DW-1:0];

  assign br_up   = ctrl[B_UPEN] && (sample > up_wm);
  assign br_lo   = ctrl[B_LOEN] && (sample < lo_wm);
  assign fire_up = br_up && (run_up == ctrl[UPN_LSB +: N_W]);
  assign fire_lo = br_lo && (run_lo == ctrl[LON_LSB +: N_W]);

  always_comb begin
    set_v = '0;
    if (sampling) begin
      set_v[S_UP] = fire_up;
      set_v[S_LO] = fire_lo;
      set_v[S_AU] = ctrl[B_AUEN] && (avg_new > av_up);
      set_v[S_AL] = ctrl[B_ALEN] && (avg_new < av_lo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; up_wm <= '0; lo_wm <= '0; av_up <= '0;
      av_lo <= '0; weight <= '0; avg <= '0; stat <= '0; acc <= '0;
      run_up <= '0; run_lo <= '0;
    end else begin
      if (wr) begin
        case (off)
          OFF_CTRL: ctrl   <= wdata;
          OFF_UPWM: up_wm  <= wdata;
          OFF_LOWM: lo_wm  <= wdata;
          OFF_AVUP: av_up  <= wdata;
          OFF_AVLO: av_lo  <= wdata;
          OFF_WGT:  weight <= wdata;
          default: ;
        endcase
      end

      if (restart || !active) acc <= '0;
      else if (sampling)      acc <= '0;
      else                    acc <= sample;

      if (init_wr)       avg <= wdata;
      else if (sampling) avg <= avg_new;

      if (restart || !active || !ctrl[B_UPEN]) run_up <= '0;
      else if (sampling) run_up <= (br_up && !fire_up) ? run_up + 1'b1 : '0;

      if (restart || !active || !ctrl[B_LOEN]) run_lo <= '0;
      else if (sampling) run_lo <= (br_lo && !fire_lo) ? run_lo + 1'b1 : '0;

      stat <= (stat & ~clr) | set_v;
    end
  end

  always_comb begin
    case (off)
      OFF_CTRL: rdata = ctrl;
      OFF_UPWM: rdata = up_wm;
      OFF_LOWM: rdata = lo_wm;
      OFF_INIT: rdata = avg;
      OFF_AVUP: rdata = av_up;
      OFF_AVLO: rdata = av_lo;
      OFF_WGT:  rdata = weight;
      OFF_AVG:  rdata = avg;
      OFF_STAT: rdata = stat;
      default:  rdata = '0;
    endcase
  end

  assign ctrl_o = ctrl;
  assign avg_o  = avg;
  assign stat_o = stat;
endmodule

// File: rtl/mem_activity_mon.sv
module mem_activity_mon
  import mam_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int CYC_PER_MS = 100000,
  parameter int PER_W      = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ev_in,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_rvalid,
  output logic [NCH-1:0] irq
);
  logic [1:0] rgn;
  logic [3:0] off;
  logic       aligned, restart, tmr_end, period_end;
  logic [PER_W-1:0] period_q;

  logic [NCH-1:0][DW-1:0] ch_rd, ch_ctrl, ch_avg, ch_stat, ch_clr;
  logic [NCH-1:0]         ch_wr, ch_init_wr;
  word_t gstat, rd_mux;

  assign rgn     = reg_addr[AW-1:AW-2];
  assign off     = reg_addr[5:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign restart = reg_wr && aligned && (rgn == 2'd0) && (off == OFF_GPER);

  always_ff @(posedge clk) begin
    if (rst)          period_q <= '0;
    else if (restart) period_q <= reg_wdata[PER_W-1:0];
  end

  mam_timer #(.CYC_PER_MS(CYC_PER_MS), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .period_m1(period_q), .period_end(tmr_end)
  );
  // a period boundary coinciding with a restart is discarded
  assign period_end = tmr_end && !restart;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wr[c]      = reg_wr && aligned && (rgn == 2'(c + 1));
    assign ch_init_wr[c] = ch_wr[c] && (off == OFF_INIT);
    assign ch_clr[c]     = (ch_wr[c] && (off == OFF_STAT)) ? reg_wdata : '0;

    mam_channel u_ch (
      .clk(clk), .rst(rst), .restart(restart), .period_end(period_end),
      .ev(ev_in[c]), .wr(ch_wr[c]), .off(off), .wdata(reg_wdata),
      .clr(ch_clr[c]), .init_wr(ch_init_wr[c]),
      .rdata(ch_rd[c]), .ctrl_o(ch_ctrl[c]), .avg_o(ch_avg[c]),
      .stat_o(ch_stat[c])
    );

    assign irq[c] = |ch_stat[c];
  end

  always_comb begin
    gstat = '0;
    for (int c = 0; c < NCH; c++) gstat[GSTAT_TOP - c] = irq[c];
  end

  always_comb begin
    rd_mux = '0;
    if (rgn == 2'd0) begin
      if (off == OFF_GSTAT)     rd_mux = gstat;
      else if (off == OFF_GPER) rd_mux = DW'(period_q);
    end else begin
      for (int c = 0; c < NCH; c++)
        if (rgn == 2'(c + 1)) rd_mux = ch_rd[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= aligned ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mam_checks.sv
module mam_checks
  import mam_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   period_end,
  input logic [NCH-1:0][DW-1:0] ctrl,
  input logic [NCH-1:0][DW-1:0] avg,
  input logic [NCH-1:0][DW-1:0] stat,
  input logic [NCH-1:0][DW-1:0] clr,
  input logic [NCH-1:0]         init_wr
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R10: a stopped channel keeps its average unless it is preloaded
    a_r10_stop_freezes_avg: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[c][B_RUN] && !init_wr[c]) |=> $stable(avg[c]));

    // R7: a set status bit survives any write that does not clear it
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
      (stat[c][S_UP] && !clr[c][S_UP]) |=> stat[c][S_UP]);

    // R4: status bits only rise on a period boundary
    a_r4_set_at_boundary: assert property (@(posedge clk) disable iff (rst)
      !period_end |=> ((stat[c] & ~$past(stat[c])) == '0));

    // R8: a disabled average-above source never sets its bit
    a_r8_avg_up_gated: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[c][B_AUEN] && !stat[c][S_AU]) |=> !stat[c][S_AU]);
  end
endmodule

bind mem_activity_mon mam_checks #(.NCH(NCH)) u_mam_checks (
  .clk(clk), .rst(rst), .period_end(period_end),
  .ctrl(ch_ctrl), .avg(ch_avg), .stat(ch_stat),
  .clr(ch_clr), .init_wr(ch_init_wr)
);

// File: tb/test_mem_activity_mon.sv
module test_mem_activity_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int CPM = 4;          // cycles per ms in the bench
  // period register 1 -> 2 ms -> 8 cycles; weight 16 -> sample 128 with event held

  localparam logic [31:0] C_RUN = 32'h8000_0000, C_UPEN = 32'h4000_0000,
                          C_LOEN = 32'h2000_0000, C_AUEN = 32'h0020_0000,
                          C_ALEN = 32'h0010_0000, C_PER  = 32'h0004_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] ev_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid;
  logic [NCH-1:0] irq;

  mem_activity_mon #(.NCH(NCH), .CYC_PER_MS(CPM)) i_mem_activity_mon (
    .clk(clk), .rst(rst), .ev_in(ev_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, t0 = 0, n_vec = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected read data %h, expected none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        n_vec++;
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read %h, expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  function automatic logic [7:0] ca(int c, int w);
    return 8'(((c + 1) << 6) | (w << 2));
  endfunction

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; t0 = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [7:0] a, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_to(int k);
    while (cyc < t0 + k) @(negedge clk);
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
    n_vec++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: saw %h, expected %h", tag, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(32'(irq), 32'h0, "R1 irq after reset");
    rd_exp(ca(0, 0), 32'h0, "R1 ctrl after reset");
    rd_exp(ca(0, 8), 32'h0, "R1 status after reset");
    rd_exp(8'h00, 32'h0, "R1 global status after reset");
    rd_exp(8'h04, 32'h0, "R1 period after reset");

    // R2/R3: average with K=0, event held high
    ev_in[0] = 1'b1;
    wr_reg(ca(0, 6), 32'd16);
    wr_reg(ca(0, 3), 32'd0);
    wr_reg(ca(0, 1), 32'hFFFF_FFFF);
    wr_reg(ca(0, 0), C_RUN | C_PER);
    wr_reg(8'h04, 32'd1);
    p = t0;
    wait_to(11); rd_exp(ca(0, 7), 32'd64, "R3 avg after 1 period K=0");
    t0 = p; wait_to(19); rd_exp(ca(0, 7), 32'd96, "R3 avg after 2 periods K=0");
    rd_exp(8'h04, 32'd1, "R2 period readback");
    rd_exp(8'h06, 32'd0, "R11 misaligned read returns zero");

    // R3: K=1 window
    wr_reg(ca(0, 0), 32'h0);
    wr_reg(ca(0, 3), 32'd0);
    wr_reg(ca(0, 0), C_RUN | C_PER | (32'd1 << 10));
    wr_reg(8'h04, 32'd1);
    wait_to(19); rd_exp(ca(0, 7), 32'd56, "R3 avg after 2 periods K=1");

    // R4/R5/R6/R7/R8/R9: consecutive-above on channel 0, run of 3
    wr_reg(ca(0, 0), 32'h0);
    wr_reg(ca(0, 8), 32'hFFFF_FFFF);
    wr_reg(ca(0, 1), 32'd100);
    wr_reg(ca(0, 4), 32'd0);
    wr_reg(ca(0, 3), 32'd0);
    wr_reg(ca(0, 0), C_RUN | C_PER | C_UPEN | (32'd2 << 26));
    wr_reg(8'h04, 32'd1);
    p = t0;
    wait_to(16); ev_in[0] = 1'b0;   // period 3 sees no events
    wait_to(24); ev_in[0] = 1'b1;
    wait_to(43); rd_exp(ca(0, 8), 32'h0, "R5 run broken by quiet period");
    t0 = p; wait_to(51);
    rd_exp(ca(0, 8), 32'h8000_0000, "R4 R8 above-run sets only bit 31");
    rd_exp(8'h00, 32'h0400_0000, "R9 global bit 26 for channel 0");
    chk(32'(irq), 32'h1, "R9 irq for channel 0");
    wr_reg(ca(0, 8), 32'h4000_0000);
    t0 = p; rd_exp(ca(0, 8), 32'h8000_0000, "R7 zero bits leave status");
    wr_reg(ca(0, 8), 32'h8000_0000);
    t0 = p; wait_to(59); rd_exp(ca(0, 8), 32'h0, "R7 ones clear status");
    t0 = p; wait_to(67); rd_exp(ca(0, 8), 32'h0, "R6 no set before new run");
    t0 = p; wait_to(75); rd_exp(ca(0, 8), 32'h8000_0000, "R6 set after new run");

    // R4/R9/R10: consecutive-below on channel 1, channel 0 stopped
    wr_reg(ca(0, 0), 32'h0);
    wr_reg(ca(0, 8), 32'hFFFF_FFFF);
    wr_reg(ca(0, 3), 32'd777);
    ev_in = 2'b11;
    wr_reg(ca(1, 6), 32'd16);
    wr_reg(ca(1, 1), 32'hFFFF_FFFF);
    wr_reg(ca(1, 2), 32'd200);
    wr_reg(ca(1, 0), C_RUN | C_PER | C_LOEN);
    wr_reg(8'h04, 32'd1);
    p = t0;
    wait_to(3); rd_exp(ca(1, 8), 32'h0, "R4 below not set before boundary");
    t0 = p; wait_to(11);
    rd_exp(ca(1, 8), 32'h4000_0000, "R4 below run of 1 sets bit 30");
    rd_exp(8'h00, 32'h0200_0000, "R9 global bit 25 for channel 1");
    chk(32'(irq), 32'h2, "R9 irq for channel 1");
    t0 = p; wait_to(27);
    rd_exp(ca(0, 7), 32'd777, "R10 stopped channel keeps preloaded avg");
    rd_exp(ca(0, 8), 32'h0, "R10 stopped channel sets no status");

    // R8: average watermarks on channel 0
    wr_reg(ca(1, 0), 32'h0);
    wr_reg(ca(1, 8), 32'hFFFF_FFFF);
    ev_in = 2'b01;
    wr_reg(ca(0, 3), 32'd0);
    wr_reg(ca(0, 1), 32'hFFFF_FFFF);
    wr_reg(ca(0, 2), 32'd0);
    wr_reg(ca(0, 4), 32'd80);
    wr_reg(ca(0, 5), 32'd0);
    wr_reg(ca(0, 0), C_RUN | C_PER | C_AUEN | C_ALEN);
    wr_reg(8'h04, 32'd1);
    p = t0;
    wait_to(11); rd_exp(ca(0, 8), 32'h0, "R8 avg 64 not above 80");
    t0 = p; wait_to(19); rd_exp(ca(0, 8), 32'h2000_0000, "R8 avg 96 above 80");

    wr_reg(ca(0, 0), 32'h0);
    wr_reg(ca(0, 8), 32'hFFFF_FFFF);
    ev_in = 2'b00;
    wr_reg(ca(0, 3), 32'd100);
    wr_reg(ca(0, 4), 32'hFFFF_FFFF);
    wr_reg(ca(0, 5), 32'd40);
    wr_reg(ca(0, 0), C_RUN | C_PER | C_ALEN);
    wr_reg(8'h04, 32'd1);
    p = t0;
    wait_to(11); rd_exp(ca(0, 8), 32'h0, "R8 avg 50 not below 40");
    t0 = p; wait_to(19);
    rd_exp(ca(0, 8), 32'h1000_0000, "R8 avg 25 below 40");
    rd_exp(ca(0, 7), 32'd25, "R3 avg decays with floor");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule